// File: doc/BRIEF.md
# Multi-Shape Phase-Accumulator Oscillator

This block produces unsigned sample codes for a single DAC channel. Every pulse on `sample_en` advances a 32-bit phase accumulator by the frequency word. A phase offset, given in whole degrees, is added after the accumulator, so the running phase itself never moves. The resulting phase is mapped to one of four shapes: sawtooth, sine, triangle or square. The signed wave is then multiplied by a 12-bit amplitude and shifted back to offset binary, centred on 2048. One cycle later the code appears on `out_code` together with a one-cycle `out_valid` pulse.

With a 1 MHz strobe, one LSB of the frequency word is about 0.23 mHz, so the range runs from DC to well past several kilohertz. A frequency word of zero freezes the phase. The output is then a static level set only by the phase offset and the amplitude. Shape, amplitude and offset are captured only on a strobe, so a sample never mixes an old setting with a new one. A full system instantiates one copy per analog output channel.

Top module: `wave_nco`

## Requirements
- R1: On each clock edge with `sample_en` high, the accumulator becomes (accumulator + `freq_word`) mod 2^32. On other edges it keeps its value. Reset clears it to 0.
- R2: The effective phase is (accumulator + D * 11930465) mod 2^32, where D is the captured `phase_deg`. A `phase_deg` value above 359 is treated as 359. The offset never changes the accumulator.
- R3: The `shape` encoding is 0 sawtooth, 1 sine, 2 triangle and 3 square. The signed sawtooth value is P[31:20] - 2048, where P is the effective phase.
- R4: The sine value uses quadrant Q = P[31:30] and index I = P[29:22]. With J = I for Q = 0 or 2, and J = 255 - I for Q = 1 or 3, the magnitude is round(2047 * sin(pi * (J + 0.5) / 512)). The value is negative for Q = 2 and Q = 3.
- R5: The triangle takes X = P[31:19] and T = X when X < 4096, otherwise 8191 - X; its value is T - 2048, rising over the first half cycle and falling over the second. The square value is +2047 while P[31] = 0 and -2047 otherwise.
- R6: For signed wave W and amplitude A, `out_code` = 2048 + floor(W * A / 4096). An amplitude of 0 gives 2048.
- R7: A strobe sampled at edge k yields `out_valid` high for exactly the cycle after edge k+1. `out_code` changes only on edges that raise `out_valid` and holds otherwise.
- R8: `shape`, `amp` and `phase_deg` are captured only on strobe edges. Changes between strobes do not affect any output until the next strobe's sample.
- R9: With `freq_word` = 0 the output is a static level set by the offset, shape and amplitude. For example, sine at 90 degrees with A = 4095 gives 4094.
- R10: During and right after reset, `out_code` is 2048 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample strobe; advances the phase and captures the settings |
| freq_word | input | 32 | Phase increment per strobe |
| phase_deg | input | 9 | Phase offset in degrees, 0 to 359 |
| amp | input | 12 | Amplitude multiplier, full scale 4095 |
| shape | input | 2 | Wave shape selector |
| out_code | output | 12 | Offset-binary sample code |
| out_valid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The assertions assume that `sample_en` is sampled on clean edges and that `phase_deg` is normally 0 to 359. Out-of-range degrees are legal but saturate. The strobe may be high on consecutive cycles. The timing properties are written so that back-to-back strobes still yield one valid pulse per strobe, two edges later. The bench keeps every input stable across each rising edge. It drives strobes with gaps of zero to three cycles, and it deliberately uses one degree value above 359 to exercise saturation.

// File: rtl/wave_nco_pkg.sv
package wave_nco_pkg;

  typedef enum logic [1:0] {
    SHP_SAW  = 2'd0,
    SHP_SINE = 2'd1,
    SHP_TRI  = 2'd2,
    SHP_SQR  = 2'd3
  } shape_e;

  localparam real HALF_PI_NUM = 3.14159265358979;

  // Quarter-wave magnitude at the centre of table slot idx.
  function automatic int quarter_sine(input int idx, input int depth, input int peak);
    real ang;
    ang = HALF_PI_NUM * (real'(idx) + 0.5) / (2.0 * real'(depth));
    return $rtoi(real'(peak) * $sin(ang) + 0.5);
  endfunction

  // Degree count to phase-word step, rounded.
  function automatic logic [63:0] deg_step(input int acc_w);
    logic [63:0] full;
    full = 64'd1 << acc_w;
    return (full + 64'd180) / 64'd360;
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int DEG_W = 9,
  parameter int AMP_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en,
  input  logic [ACC_W-1:0]     freq_word,
  input  logic [DEG_W-1:0]     phase_deg,
  input  logic [AMP_W-1:0]     amp,
  input  wave_nco_pkg::shape_e shape,
  output logic [ACC_W-1:0]     acc_q,
  output logic [DEG_W-1:0]     deg_q,
  output logic [AMP_W-1:0]     amp_q,
  output wave_nco_pkg::shape_e shape_q,
  output logic                 stage_v
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      deg_q   <= '0;
      amp_q   <= '0;
      shape_q <= wave_nco_pkg::SHP_SAW;
      stage_v <= 1'b0;
    end else begin
      stage_v <= sample_en;
      if (sample_en) begin
        acc_q   <= acc_q + freq_word;
        deg_q   <= phase_deg;
        amp_q   <= amp;
        shape_q <= shape;
      end
    end
  end

endmodule

// File: rtl/nco_offset.sv
module nco_offset #(
  parameter int ACC_W = 32,
  parameter int DEG_W = 9,
  parameter int TOP_W = 13
) (
  input  logic [ACC_W-1:0] acc_q,
  input  logic [DEG_W-1:0] deg_q,
  output logic [TOP_W-1:0] phase_top
);

  localparam logic [63:0]      STEP64   = wave_nco_pkg::deg_step(ACC_W);
  localparam logic [ACC_W-1:0] DEG_STEP = STEP64[ACC_W-1:0];
  localparam logic [DEG_W-1:0] DEG_MAX  = DEG_W'(359);
  localparam int               SHIFT    = ACC_W - TOP_W;

  logic [DEG_W-1:0] deg_sat;
  logic [ACC_W-1:0] off_word;

  always_comb begin
    deg_sat   = (deg_q > DEG_MAX) ? DEG_MAX : deg_q;
    off_word  = ACC_W'(deg_sat * DEG_STEP);
    phase_top = TOP_W'((acc_q + off_word) >> SHIFT);
  end

endmodule

// File: rtl/nco_shape_map.sv
module nco_shape_map #(
  parameter int OUT_W  = 12,
  parameter int LUT_AW = 8,
  parameter int TOP_W  = 13
) (
  input  logic [TOP_W-1:0]        phase_top,
  input  wave_nco_pkg::shape_e    shape_q,
  output logic signed [OUT_W-1:0] wave
);

  localparam int LUT_D = 1 << LUT_AW;
  localparam int PEAK  = (1 << (OUT_W - 1)) - 1;

  logic [OUT_W-1:0] qtab [LUT_D];

  for (genvar g = 0; g < LUT_D; g++) begin : g_qtab
    assign qtab[g] = OUT_W'(wave_nco_pkg::quarter_sine(g, LUT_D, PEAK));
  end

  logic [OUT_W-1:0]  saw_top, tri_x, tri_t;
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx, idx_m;
  logic [OUT_W-1:0]  mag;

  always_comb begin
    saw_top = phase_top[TOP_W-1 -: OUT_W];
    tri_x   = phase_top[TOP_W-2 -: OUT_W];
    tri_t   = phase_top[TOP_W-1] ? ~tri_x : tri_x;
    quad    = phase_top[TOP_W-1 -: 2];
    idx     = phase_top[TOP_W-3 -: LUT_AW];
    idx_m   = quad[0] ? ~idx : idx;
    mag     = qtab[idx_m];
    unique case (shape_q)
      wave_nco_pkg::SHP_SAW:  wave = $signed({~saw_top[OUT_W-1], saw_top[OUT_W-2:0]});
      wave_nco_pkg::SHP_SINE: wave = quad[1] ? -$signed(mag) : $signed(mag);
      wave_nco_pkg::SHP_TRI:  wave = $signed({~tri_t[OUT_W-1], tri_t[OUT_W-2:0]});
      default:                wave = phase_top[TOP_W-1] ? OUT_W'(-PEAK) : OUT_W'(PEAK);
    endcase
  end

endmodule

// File: rtl/nco_amp_scale.sv
module nco_amp_scale #(
  parameter int OUT_W = 12,
  parameter int AMP_W = 12
) (
  input  logic signed [OUT_W-1:0] wave,
  input  logic [AMP_W-1:0]        amp_q,
  output logic [OUT_W-1:0]        code
);

  localparam int               PW  = OUT_W + AMP_W + 1;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  logic signed [PW-1:0] w_ext, a_ext, prod;

  always_comb begin
    w_ext = {{(PW - OUT_W){wave[OUT_W-1]}}, wave};
    a_ext = {{(PW - AMP_W){1'b0}}, amp_q};
    prod  = w_ext * a_ext;
    code  = OUT_W'(prod >>> AMP_W) + MID;
  end

endmodule

// File: rtl/wave_nco.sv
module wave_nco #(
  parameter int ACC_W  = 32,
  parameter int DEG_W  = 9,
  parameter int AMP_W  = 12,
  parameter int OUT_W  = 12,
  parameter int LUT_AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [ACC_W-1:0] freq_word,
  input  logic [DEG_W-1:0] phase_deg,
  input  logic [AMP_W-1:0] amp,
  input  logic [1:0]       shape,
  output logic [OUT_W-1:0] out_code,
  output logic             out_valid
);

  localparam int TOP_W = (OUT_W + 1 > LUT_AW + 2) ? OUT_W + 1 : LUT_AW + 2;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  logic [ACC_W-1:0]        acc_q;
  logic [DEG_W-1:0]        deg_q;
  logic [AMP_W-1:0]        amp_q;
  wave_nco_pkg::shape_e    shape_q;
  logic                    stage_v;
  logic [TOP_W-1:0]        phase_top;
  logic signed [OUT_W-1:0] wave;
  logic [OUT_W-1:0]        code_next;

  nco_phase_acc #(.ACC_W(ACC_W), .DEG_W(DEG_W), .AMP_W(AMP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .freq_word(freq_word),
    .phase_deg(phase_deg), .amp(amp), .shape(wave_nco_pkg::shape_e'(shape)),
    .acc_q(acc_q), .deg_q(deg_q), .amp_q(amp_q), .shape_q(shape_q), .stage_v(stage_v)
  );

  nco_offset #(.ACC_W(ACC_W), .DEG_W(DEG_W), .TOP_W(TOP_W)) u_off (
    .acc_q(acc_q), .deg_q(deg_q), .phase_top(phase_top)
  );

  nco_shape_map #(.OUT_W(OUT_W), .LUT_AW(LUT_AW), .TOP_W(TOP_W)) u_map (
    .phase_top(phase_top), .shape_q(shape_q), .wave(wave)
  );

  nco_amp_scale #(.OUT_W(OUT_W), .AMP_W(AMP_W)) u_scl (
    .wave(wave), .amp_q(amp_q), .code(code_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_code  <= MID;
      out_valid <= 1'b0;
    end else begin
      out_valid <= stage_v;
      if (stage_v) out_code <= code_next;
    end
  end

endmodule

// File: rtl/wave_nco_chk.sv
module wave_nco_chk #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 12,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic [ACC_W-1:0] freq_word,
  input logic [ACC_W-1:0] acc_q,
  input logic [AMP_W-1:0] amp_q,
  input logic [OUT_W-1:0] out_code,
  input logic             out_valid
);

  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

  assert_acc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> acc_q == $past(acc_q) + $past(freq_word));

  assert_acc_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(acc_q));

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> ##1 out_valid);

  assert_valid_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(sample_en, 2));

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_code));

  assert_zero_amp_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(amp_q) == '0) |-> out_code == MID);

endmodule

bind wave_nco wave_nco_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .freq_word(freq_word),
  .acc_q(acc_q), .amp_q(amp_q), .out_code(out_code), .out_valid(out_valid)
);

// File: tb/wave_nco_tb.sv
module wave_nco_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic [31:0] freq_word = '0;
  logic [8:0]  phase_deg = '0;
  logic [11:0] amp = '0;
  logic [1:0]  shape = '0;
  logic [11:0] out_code;
  logic        out_valid;

  always #4 clk = ~clk;

  wave_nco u_dut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .freq_word(freq_word),
    .phase_deg(phase_deg), .amp(amp), .shape(shape),
    .out_code(out_code), .out_valid(out_valid)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R10";

  // Behavioural reference, built straight from the requirements.
  function automatic int ref_code(longint acc, int deg, int shp, int a);
    longint p;
    int d, w, q, i, j, m, x;
    d = (deg > 359) ? 359 : deg;
    p = (acc + longint'(d) * 11930465) % 64'd4294967296;
    case (shp)
      0: w = int'(p / 1048576) - 2048;
      1: begin
        q = int'(p / 1073741824);
        i = int'(p / 4194304) % 256;
        j = (q == 1 || q == 3) ? 255 - i : i;
        m = $rtoi(2047.0 * $sin(3.14159265358979 * (real'(j) + 0.5) / 512.0) + 0.5);
        w = (q >= 2) ? -m : m;
      end
      2: begin
        x = int'(p / 524288);
        w = ((x < 4096) ? x : 8191 - x) - 2048;
      end
      default: w = (p < 64'd2147483648) ? 2047 : -2047;
    endcase
    return 2048 + ((w * a) >>> 12);
  endfunction

  longint m_acc;
  int     m_deg, m_amp, m_shp, m_out;
  bit     m_pend, m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_deg = 0; m_amp = 0; m_shp = 0;
      m_pend = 0; m_valid = 0; m_out = 2048;
    end else begin
      m_valid = m_pend;
      if (m_pend) m_out = ref_code(m_acc, m_deg, m_shp, m_amp);
      m_pend = sample_en;
      if (sample_en) begin
        m_acc = (m_acc + longint'(freq_word)) % 64'd4294967296;
        m_deg = int'(phase_deg);
        m_amp = int'(amp);
        m_shp = int'(shape);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (out_valid !== m_valid || int'(out_code) !== m_out) begin
        n_fail++;
        $display("FAIL %s model compare: actual code %0d valid %0d expected code %0d valid %0d",
                 cur_req, out_code, out_valid, m_out, m_valid);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe(input int gap);
    @(negedge clk); sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // One strobe, returns the code at the cycle out_valid is expected high.
  task automatic one_sample(output int code);
    @(negedge clk); sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    @(negedge clk);
    code = int'(out_code);
  endtask

  task automatic setcfg(input int s, input int d, input int a, input logic [31:0] f);
    @(negedge clk);
    shape = 2'(s); phase_deg = 9'(d); amp = 12'(a); freq_word = f;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c, c2, s;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 reset code", int'(out_code), 2048);
    chk("R10 reset valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset code", int'(out_code), 2048);

    // R1 / R3 sawtooth stepping and wrap
    cur_req = "R1";
    setcfg(0, 0, 4095, 32'h1000_0000);
    for (int k = 1; k <= 16; k++) begin
      one_sample(c);
      if (k == 1)  chk("R3 saw first step", c, 256);
      if (k == 8)  chk("R1 saw half cycle", c, 2048);
      if (k == 16) chk("R1 wrap to zero phase", c, 0);
    end

    // R7 valid timing
    cur_req = "R7";
    @(negedge clk); sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    chk("R7 no valid after first edge", int'(out_valid), 0);
    @(negedge clk);
    chk("R7 valid after second edge", int'(out_valid), 1);
    @(negedge clk);
    chk("R7 single-cycle pulse", int'(out_valid), 0);

    // R1 sweeps with varied gaps and wrap-heavy increments
    cur_req = "R1";
    setcfg(0, 30, 3000, 32'hF000_0001);
    for (int k = 0; k < 40; k++) strobe(k % 4);

    // R4 sine sweep, gapped and back-to-back
    cur_req = "R4";
    setcfg(1, 0, 4095, 32'h0400_0000);
    for (int k = 0; k < 70; k++) strobe(k % 3);
    @(negedge clk); sample_en = 1'b1;
    repeat (30) @(negedge clk);
    sample_en = 1'b0;
    repeat (3) @(negedge clk);

    // R5 triangle and square sweeps
    cur_req = "R5";
    setcfg(2, 45, 4095, 32'h0300_0000);
    for (int k = 0; k < 60; k++) strobe(1);
    setcfg(3, 10, 2500, 32'h0500_0000);
    for (int k = 0; k < 60; k++) strobe(0);

    // R6 amplitude levels
    cur_req = "R6";
    for (int a = 0; a < 4; a++) begin
      setcfg(1, 0, a * 1365, 32'h0700_0000);
      for (int k = 0; k < 20; k++) strobe(1);
    end

    // R8 settings between strobes have no effect
    cur_req = "R8";
    setcfg(2, 20, 4000, 32'h0200_0000);
    one_sample(c);
    setcfg(3, 200, 100, 32'h0900_0000);
    repeat (4) @(negedge clk);
    chk("R8 code held after setting change", int'(out_code), c);
    chk("R8 no valid after setting change", int'(out_valid), 0);
    for (int k = 0; k < 10; k++) strobe(2);

    // R9 / R2 static levels from phase offset
    cur_req = "R9";
    do_reset();
    setcfg(1, 90, 4095, 32'h0);
    one_sample(c); chk("R9 sine 90 deg static", c, 4094);
    one_sample(c); chk("R9 static level repeats", c, 4094);
    setcfg(1, 90, 1000, 32'h0);
    one_sample(c); chk("R6 sine 90 deg amp 1000", c, 2547);
    setcfg(3, 0, 4095, 32'h0);
    one_sample(c); chk("R5 square first half", c, 4094);
    setcfg(3, 180, 4095, 32'h0);
    one_sample(c); chk("R5 square second half", c, 1);
    setcfg(2, 0, 4095, 32'h0);
    one_sample(c); chk("R5 triangle at 0 deg", c, 0);
    setcfg(2, 90, 4095, 32'h0);
    one_sample(c); chk("R5 triangle at 90 deg", c, 2048);
    setcfg(0, 0, 0, 32'h0);
    one_sample(c); chk("R6 zero amplitude midscale", c, 2048);
    cur_req = "R2";
    setcfg(1, 359, 4095, 32'h0);
    one_sample(c); chk("R2 sine 359 deg", c, 2017);
    setcfg(1, 400, 4095, 32'h0);
    one_sample(c2); chk("R2 degrees above 359 saturate", c2, c);
    for (int d = 0; d < 360; d += 37) begin
      s = d % 4;
      setcfg(s, d, 3333, 32'h0);
      strobe(0);
    end
    // R2 offset leaves accumulator alone: same phase after offset change
    setcfg(0, 0, 4095, 32'h0);
    one_sample(c); chk("R2 offset does not move accumulator", c, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule